// File: doc/BRIEF.md
# Attribute-Cell Color Pixel Renderer

This block turns a one-bit-per-pixel bitmap into a stream of 4-bit color indices for a raster display. Color comes from one attribute byte per 8x8 pixel cell. The picture is 256 pixels wide and 192 lines tall. Every bitmap byte covers eight horizontally adjacent pixels. A set pixel takes the cell's foreground color and a clear pixel takes its background color. The attribute byte also holds a brightness flag, which applies to the whole cell. It holds a flash flag too, which swaps foreground and background during alternate flash phases.

The surrounding video timing supplies three signals: a pixel clock enable, a strobe at the start of each displayed line, and a strobe at the start of each frame. The renderer reads bitmap and attribute bytes through a synchronous read port with one cycle of latency. It fetches the next 8-pixel group while the current group is shifting out, so the two groups follow each other without a gap. Outside the active picture the output shows a border color supplied on an input.

Top module: `cellColorRenderer`

## Requirements
- R1: A `lineStart` taken with `pixEn` starts a line. The 8 pixel enables that follow, including the one that ends the lead-in, show the border with `pixActive` low. The pixel enables after that show 256 active pixels. After the 264th enable that follows the start, the output returns to the border with `pixActive` low.
- R2: The bitmap byte for line L and column group c is read at address L*32 + c. Its bits are shown most significant first, one per pixel enable. Active pixel p of a line is shown after the (8+p)th pixel enable that follows the start.
- R3: A set pixel bit shows the foreground color from attribute bits 2:0. A clear pixel bit shows the background color from attribute bits 5:3.
- R4: The attribute byte for line L and group c is read at address 6144 + (L/8)*32 + c. All eight lines of a cell row share it.
- R5: During active pixels `pixColor` is {bright, color[2:0]}, where bright is attribute bit 6. Brightness applies to the foreground and the background alike.
- R6: Attribute bit 7 swaps foreground and background while the flash phase is 1. The phase is 0 after reset and toggles on every 16th `frameStart`. It changes only at a `frameStart`.
- R7: During reset, and whenever `pixActive` is low, `pixColor` is {0, borderColor}.
- R8: Each 8-pixel group costs exactly two read cycles, in this order: the bitmap address, then the attribute address on the next clock. A full line makes 64 read cycles. `memRd` is low at all other times.
- R9: `frameStart` resets the line count to 0. Once 192 lines have been shown, `lineStart` has no effect until the next `frameStart`: no reads are made and `pixActive` stays low.
- R10: Between pixel enables, `pixActive` and the pixel shown hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel clock enable; one pixel per asserted cycle |
| lineStart | input | 1 | Start of a displayed line, taken only together with pixEn |
| frameStart | input | 1 | Start of a frame; resets the line count and advances the flash counter |
| borderColor | input | 3 | Color shown outside the active picture |
| memAddr | output | 13 | Byte address for the read port |
| memRd | output | 1 | Read request; data is returned on the next clock |
| memData | input | 8 | Read data from the previous request |
| pixColor | output | 4 | {bright, color index} |
| pixActive | output | 1 | High while an active pixel is shown |

## Verification
The bench computes every pixel of whole lines from the memory image. An off-by-one in the lead-in or the group boundary would shift the whole line by one pixel or one group. A bit-order error would mirror each byte. It uses lines past each 8-line cell row boundary: an attribute row computed from the wrong line would color those lines from a neighboring row. Random gaps in the pixel enable expose any register that advances on the clock instead of the enable. The flash phase is checked just before and just after the 16th and 32nd frame strobes, and a 193rd line request must stay dark and make no reads.

// File: rtl/cellRendPkg.sv
package cellRendPkg;
  localparam int CELL_PX    = 8;
  localparam int CELL_SHIFT = $clog2(CELL_PX);

  typedef struct packed {
    logic loadGrp;     // move prefetched bytes into the shifter
    logic shiftPix;    // advance one pixel
    logic capBmp;      // memData holds the bitmap byte
    logic capAttr;     // memData holds the attribute byte
    logic active;      // inside the active picture
    logic flashPhase;  // current flash phase
  } ctrlStrobeT;
endpackage

// File: rtl/cellRendCtrl.sv
module cellRendCtrl
  import cellRendPkg::*;
#(
  parameter int H_PIX        = 256,
  parameter int V_LINES      = 192,
  parameter int ATTR_BASE    = 6144,
  parameter int ADDR_W       = 13,
  parameter int FLASH_FRAMES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              lineStart,
  input  logic              frameStart,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output ctrlStrobeT        strobes
);
  localparam int COLS   = H_PIX / CELL_PX;
  localparam int GRP_W  = $clog2(COLS + 1);
  localparam int LINE_W = $clog2(V_LINES + 1);
  localparam int PIX_W  = $clog2(CELL_PX);
  localparam int FCNT_W = $clog2(FLASH_FRAMES);

  typedef enum logic [1:0] {F_IDLE, F_BMP, F_ATTR, F_CAP} fetchT;

  logic [PIX_W-1:0]  pixCnt;
  logic [GRP_W-1:0]  grpIdx;
  logic [GRP_W-1:0]  fetchCol;
  logic [LINE_W-1:0] lineNum;
  logic [FCNT_W-1:0] frameCnt;
  logic              inLine;
  logic              flashPhase;
  fetchT             fetchStep;

  logic lineOk, startLine, groupEnd, loadNow, fetchGo;
  logic [ADDR_W-1:0] bmpAddr, attrAddr;

  always_comb begin
    lineOk    = lineNum < LINE_W'(V_LINES);
    startLine = pixEn && lineStart && lineOk && !frameStart;
    groupEnd  = pixEn && inLine && !frameStart && !startLine
                && (pixCnt == PIX_W'(CELL_PX - 1));
    loadNow   = groupEnd && (grpIdx < GRP_W'(COLS));
    fetchGo   = startLine || (loadNow && (grpIdx < GRP_W'(COLS - 1)));
  end

  // line and group sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt     <= '0;
      grpIdx     <= '0;
      inLine     <= 1'b0;
      lineNum    <= '0;
      frameCnt   <= '0;
      flashPhase <= 1'b0;
    end else if (frameStart) begin
      lineNum <= '0;
      inLine  <= 1'b0;
      if (frameCnt == FCNT_W'(FLASH_FRAMES - 1)) begin
        frameCnt   <= '0;
        flashPhase <= !flashPhase;
      end else begin
        frameCnt <= frameCnt + 1'b1;
      end
    end else if (startLine) begin
      inLine <= 1'b1;
      pixCnt <= '0;
      grpIdx <= '0;
    end else if (pixEn && inLine) begin
      pixCnt <= pixCnt + 1'b1;
      if (groupEnd) begin
        if (grpIdx == GRP_W'(COLS)) begin
          inLine  <= 1'b0;
          lineNum <= lineNum + 1'b1;
        end else begin
          grpIdx <= grpIdx + 1'b1;
        end
      end
    end
  end

  // two-read fetch sequence per group
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchStep <= F_IDLE;
      fetchCol  <= '0;
    end else if (fetchGo) begin
      fetchStep <= F_BMP;
      fetchCol  <= startLine ? '0 : grpIdx + 1'b1;
    end else begin
      unique case (fetchStep)
        F_BMP:   fetchStep <= F_ATTR;
        F_ATTR:  fetchStep <= F_CAP;
        default: fetchStep <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    bmpAddr  = ADDR_W'(lineNum) * ADDR_W'(COLS) + ADDR_W'(fetchCol);
    attrAddr = ADDR_W'(ATTR_BASE) + ADDR_W'(lineNum >> CELL_SHIFT) * ADDR_W'(COLS)
               + ADDR_W'(fetchCol);
    memAddr  = (fetchStep == F_ATTR) ? attrAddr : bmpAddr;
    memRd    = (fetchStep == F_BMP) || (fetchStep == F_ATTR);

    strobes.loadGrp    = loadNow;
    strobes.shiftPix   = pixEn && inLine && !loadNow;
    strobes.capBmp     = fetchStep == F_ATTR;
    strobes.capAttr    = fetchStep == F_CAP;
    strobes.active     = inLine && (grpIdx != '0);
    strobes.flashPhase = flashPhase;
  end
endmodule

// File: rtl/cellRendDatapath.sv
module cellRendDatapath
  import cellRendPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] memData,
  input  logic [2:0] borderColor,
  input  ctrlStrobeT strobes,
  output logic [3:0] pixColor,
  output logic       pixActive
);
  logic [CELL_PX-1:0] nextBmp, shiftReg;
  logic [7:0]         nextAttr, attrLatch;
  logic               pickFg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextBmp   <= '0;
      nextAttr  <= '0;
      shiftReg  <= '0;
      attrLatch <= '0;
    end else begin
      if (strobes.capBmp)  nextBmp  <= memData;
      if (strobes.capAttr) nextAttr <= memData;
      if (strobes.loadGrp) begin
        shiftReg  <= nextBmp;
        attrLatch <= nextAttr;
      end else if (strobes.shiftPix) begin
        shiftReg <= {shiftReg[CELL_PX-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    pickFg    = shiftReg[CELL_PX-1] ^ (attrLatch[7] & strobes.flashPhase);
    pixActive = strobes.active;
    if (strobes.active)
      pixColor = {attrLatch[6], pickFg ? attrLatch[2:0] : attrLatch[5:3]};
    else
      pixColor = {1'b0, borderColor};
  end
endmodule

// File: rtl/cellColorRenderer.sv
module cellColorRenderer
  import cellRendPkg::*;
#(
  parameter int H_PIX        = 256,
  parameter int V_LINES      = 192,
  parameter int ATTR_BASE    = 6144,
  parameter int ADDR_W       = 13,
  parameter int FLASH_FRAMES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic [2:0]        borderColor,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [7:0]        memData,
  output logic [3:0]        pixColor,
  output logic              pixActive
);
  ctrlStrobeT strobes;

  cellRendCtrl #(
    .H_PIX(H_PIX), .V_LINES(V_LINES), .ATTR_BASE(ATTR_BASE),
    .ADDR_W(ADDR_W), .FLASH_FRAMES(FLASH_FRAMES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineStart(lineStart),
    .frameStart(frameStart), .memAddr(memAddr), .memRd(memRd), .strobes(strobes)
  );

  cellRendDatapath dp (
    .clk(clk), .rstN(rstN), .memData(memData), .borderColor(borderColor),
    .strobes(strobes), .pixColor(pixColor), .pixActive(pixActive)
  );
endmodule

// File: rtl/cellRendChecks.sv
module cellRendChecks #(
  parameter int ATTR_BASE = 6144,
  parameter int ADDR_W    = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixEn,
  input logic              frameStart,
  input logic [2:0]        borderColor,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic [3:0]        pixColor,
  input logic              pixActive
);
  AST_BORDER_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !pixActive |-> pixColor == {1'b0, borderColor}); // R7

  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRd) |=> memRd); // R8

  AST_READ_END: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |=> !memRd); // R8

  AST_BMP_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !$past(memRd)) |-> memAddr < ADDR_W'(ATTR_BASE)); // R2

  AST_ATTR_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> memAddr >= ADDR_W'(ATTR_BASE)); // R4

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!pixEn && !frameStart) |=> $stable(pixActive)); // R10
endmodule

bind cellColorRenderer cellRendChecks #(.ATTR_BASE(ATTR_BASE), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .pixEn(pixEn), .frameStart(frameStart),
  .borderColor(borderColor), .memAddr(memAddr), .memRd(memRd),
  .pixColor(pixColor), .pixActive(pixActive)
);

// File: tb/cellColorRenderer_test.sv
`timescale 1ns/1ps
module cellColorRenderer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixEn = 1'b0, lineStart = 1'b0, frameStart = 1'b0;
  logic [2:0]  borderColor = 3'd0;
  logic [12:0] memAddr;
  logic        memRd;
  logic [7:0]  memData = 8'h00;
  logic [3:0]  pixColor;
  logic        pixActive;

  logic [7:0] mem [0:8191];
  int tests = 0, fails = 0, frames = 0, rdCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cellColorRenderer uut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineStart(lineStart),
    .frameStart(frameStart), .borderColor(borderColor), .memAddr(memAddr),
    .memRd(memRd), .memData(memData), .pixColor(pixColor), .pixActive(pixActive)
  );

  always @(posedge clk) begin
    if (memRd) begin
      memData <= mem[memAddr];
      rdCount <= rdCount + 1;
    end
  end

  function automatic logic [3:0] expPix(int line, int p);
    logic [7:0] bmp, attr;
    logic phase, sel;
    bmp   = mem[line * 32 + p / 8];
    attr  = mem[6144 + (line / 8) * 32 + p / 8];
    phase = ((frames / 16) % 2) == 1;
    sel   = bmp[7 - (p % 8)] ^ (attr[7] & phase);
    return {attr[6], sel ? attr[2:0] : attr[5:3]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit pe, bit ls, bit fs);
    pixEn = pe; lineStart = ls; frameStart = fs;
    @(posedge clk);
    @(negedge clk);
    pixEn = 1'b0; lineStart = 1'b0; frameStart = 1'b0;
  endtask

  task automatic newFrame();
    step(1'b0, 1'b0, 1'b1);
    frames++;
  endtask

  task automatic runLine(int line, bit valid, int gapPct, string tag);
    int n = 0;
    int rd0;
    logic [2:0] bc;
    logic [4:0] e;
    string t;
    bc = 3'($urandom % 8);
    borderColor = bc;
    rd0 = rdCount;
    step(1'b1, 1'b1, 1'b0);
    check(valid ? "R1" : "R9", "after start", {pixActive, pixColor}, {2'b00, bc});
    while (n < 270) begin
      bit pe;
      pe = ($urandom % 100) >= gapPct;
      step(pe, 1'b0, 1'b0);
      if (pe) n++;
      if (valid && n >= 8 && n < 264) e = {1'b1, expPix(line, n - 8)};
      else e = {2'b00, bc};
      if (!pe) t = "R10";
      else if (!valid) t = "R9";
      else if (n >= 8 && n < 264) t = tag;
      else t = "R1";
      check(t, $sformatf("line %0d enable %0d", line, n), {pixActive, pixColor}, e);
    end
    check("R8", $sformatf("reads on line %0d", line), rdCount - rd0, valid ? 64 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8192; i++) mem[i] = 8'($urandom);
    for (int c = 0; c < 32; c += 2) mem[6144 + c] = mem[6144 + c] | 8'h80;
    mem[0]    = 8'h80;  // single MSB pixel, line 0 group 0
    mem[32]   = 8'h0F;  // line 1 group 0, same attribute row
    mem[6144] = 8'h47;  // bright, background 0, foreground 7, no flash

    borderColor = 3'd5;
    repeat (3) @(negedge clk);
    check("R7", "reset output", {pixActive, pixColor}, {2'b00, 3'd5});
    check("R8", "reset read", memRd, 0);
    rstN = 1'b1;
    @(negedge clk);

    newFrame();
    for (int l = 0; l < 192; l++) begin
      string tg;
      if (l == 0) tg = "R2";
      else if (l == 1 || l == 8 || l == 9) tg = "R4";
      else if (l == 2) tg = "R5";
      else tg = "R3";
      runLine(l, 1'b1, (l % 5 == 4) ? 30 : 0, tg);
    end
    runLine(192, 1'b0, 0, "R9");

    while (frames < 15) newFrame();
    runLine(0, 1'b1, 0, "R6");
    newFrame();
    for (int l = 0; l < 10; l++) runLine(l, 1'b1, (l > 3) ? 20 : 0, (l < 4) ? "R6" : "R3");
    while (frames < 31) newFrame();
    runLine(0, 1'b1, 0, "R6");
    newFrame();
    runLine(0, 1'b1, 10, "R6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule